// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block guesses whether a conditional branch will be taken. It keeps a global record of the most recent branch outcomes in a short shift register. It also keeps a table of small saturating counters. A few low address bits of the branch select a row of that table. The global record then selects one counter inside that row. With an m-bit record and n-bit counters, each row holds 2^m counters. The whole table therefore holds 2^m × n × rows bits, where rows is 2^ROW_BITS.

Fetch sends a request on the predict stream and gets a taken/not-taken bit back in the same cycle. The same response also returns the history value that was used. The pipeline keeps that value with the branch. When the branch resolves, the pipeline sends an update carrying the branch address, the real outcome and the saved history. The update trains the counter that made the prediction and shifts the outcome into the global record.

Both streams are valid/ready. Neither stream ever applies back-pressure: `pq_ready` and `up_ready` are held high. A transfer therefore happens in every cycle where valid is high. The predict response is valid combinationally in the same cycle as its request, and it cannot be stalled.

Top module: `corr_bpred`

## Requirements
- R1: Each accepted update shifts the global history left by one bit and puts the real outcome into bit 0, so the newest outcome is at the LSB. In any cycle without an accepted update, the history keeps its value.
- R2: The row is chosen by `pc[PC_LSB+ROW_BITS-1:PC_LSB]` (bits 5:2 by default). There is no tag check, so addresses that differ only outside those bits share one row.
- R3: Inside the chosen row, the counter is picked by the current global history. `pr_hist` returns that history value along with the prediction.
- R4: The prediction is the counter's MSB. For 2-bit counters, states 11 and 10 give taken, and states 01 and 00 give not taken.
- R5: A taken update adds one to the counter and a not-taken update subtracts one. The counter saturates at all-ones and at zero.
- R6: An update trains the counter picked by `up_pc` and `up_hist`, not the counter picked by the live history.
- R7: After reset, the history is zero and every counter holds the weakly not-taken value 2^(n-1)-1, which is 01 for n = 2 and 0 for n = 1.
- R8: If a prediction and an update use the same counter in the same cycle, the prediction shows the counter's value from before the update.
- R9: `pq_ready` and `up_ready` are always high. `pr_valid` follows `pq_valid`. `pr_taken` is 0 whenever `pq_valid` is low.
- R10: With HIST_W = 1 and CTR_W = 1, each update replaces the single bit of the chosen counter with the real outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pq_valid | input | 1 | Predict request valid |
| pq_ready | output | 1 | Predict request ready (always 1) |
| pq_pc | input | PC_W | Fetch address to predict |
| pr_valid | output | 1 | Prediction response valid (same cycle) |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_hist | output | HIST_W | History used for this prediction |
| up_valid | input | 1 | Update valid |
| up_ready | output | 1 | Update ready (always 1) |
| up_pc | input | PC_W | Resolved branch address |
| up_taken | input | 1 | Real outcome, 1 = taken |
| up_hist | input | HIST_W | History saved at prediction time |

## Verification
Assertions check every counter on every cycle. A counter must hold its value when it is not written and move one step on a write. It must stay put at the top and bottom limits, and it must come out of reset weakly not taken. Assertions also check that the history register holds or shifts correctly, with the outcome entering at the LSB.

Some behaviours depend on how the index is built, and only the bench scenarios can show them:
- row aliasing through the upper address bits;
- the choice of column by history;
- training through the saved history rather than the live one;
- the read-before-write order when a predict and an update collide;
- the one-bit (1,1) variant.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;

  // One saturating step of a direction counter whose largest value is top_val.
  function automatic int unsigned sat_step(int unsigned cur, logic dir, int unsigned top_val);
    if (dir) return (cur >= top_val) ? top_val : cur + 1;
    else     return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Largest value that still predicts not taken, for a counter of the given width.
  function automatic int unsigned weak_not_taken(int unsigned width);
    return (32'd1 << (width - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/corr_bpred_ctr.sv
module corr_bpred_ctr #(
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             dir,
  output logic [CTR_W-1:0] q
);
  import corr_bpred_pkg::*;

  localparam logic [CTR_W-1:0] TOP_V  = '1;
  localparam logic [CTR_W-1:0] INIT_V = CTR_W'(weak_not_taken(CTR_W));

  logic [CTR_W-1:0] nxt;

  always_comb nxt = CTR_W'(sat_step(32'(q), dir, 32'(TOP_V)));

  always_ff @(posedge clk) begin
    if (rst)     q <= INIT_V;
    else if (we) q <= nxt;
  end

  p_reset_weak_r7: assert property (@(posedge clk) rst |=> q == INIT_V)
    else $error("counter not weakly not-taken after reset");
  p_hold_r5: assert property (@(posedge clk) disable iff (rst) !we |=> $stable(q))
    else $error("counter changed without write");
  p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
      we && dir && q != TOP_V |=> q == CTR_W'($past(q) + 1'b1))
    else $error("counter failed to step up");
  p_step_dn_r5: assert property (@(posedge clk) disable iff (rst)
      we && !dir && q != '0 |=> q == CTR_W'($past(q) - 1'b1))
    else $error("counter failed to step down");
  p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
      we && dir && q == TOP_V |=> q == TOP_V)
    else $error("counter wrapped past top");
  p_sat_bot_r5: assert property (@(posedge clk) disable iff (rst)
      we && !dir && q == '0 |=> q == '0)
    else $error("counter wrapped below zero");

endmodule

// File: rtl/corr_bpred_table.sv
module corr_bpred_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_dir
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [CTR_W-1:0] cells [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    corr_bpred_ctr #(.CTR_W(CTR_W)) u_ctr (
      .clk (clk),
      .rst (rst),
      .we  (sel),
      .dir (wr_dir),
      .q   (cells[e])
    );
  end

  // Reads come from the registers, so a same-cycle write is not yet visible.
  always_comb rd_ctr = cells[rd_idx];

endmodule

// File: rtl/corr_bpred_hist.sv
module corr_bpred_hist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W:0] widened;

  always_comb widened = {hist, bit_in};

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= widened[HIST_W-1:0];
  end

  p_reset_clear_r7: assert property (@(posedge clk) rst |=> hist == '0)
    else $error("history not cleared by reset");
  p_newest_lsb_r1: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> hist[0] == $past(bit_in))
    else $error("newest outcome not at LSB");
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(hist))
    else $error("history moved without update");

  if (HIST_W > 1) begin : g_body
    p_shift_body_r1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]))
      else $error("history did not shift");
  end

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int ROW_BITS = 4,
  parameter int HIST_W   = 2,
  parameter int CTR_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pq_valid,
  output logic              pq_ready,
  input  logic [PC_W-1:0]   pq_pc,
  output logic              pr_valid,
  output logic              pr_taken,
  output logic [HIST_W-1:0] pr_hist,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic [HIST_W-1:0] up_hist
);
  localparam int IDX_W  = ROW_BITS + HIST_W;
  localparam int ROW_HI = PC_LSB + ROW_BITS - 1;

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [CTR_W-1:0]  rd_ctr;
  logic              up_fire;
  logic              unused_pc_bits;

  assign pq_ready = 1'b1;
  assign up_ready = 1'b1;
  assign up_fire  = up_valid && up_ready;

  // Row from low address bits, column from history.
  assign rd_idx = {pq_pc[ROW_HI:PC_LSB], ghist};
  assign wr_idx = {up_pc[ROW_HI:PC_LSB], up_hist};

  assign unused_pc_bits = ^{pq_pc[PC_W-1:ROW_HI+1], pq_pc[PC_LSB-1:0],
                            up_pc[PC_W-1:ROW_HI+1], up_pc[PC_LSB-1:0]};

  corr_bpred_hist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (up_fire),
    .bit_in   (up_taken),
    .hist     (ghist)
  );

  corr_bpred_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (rd_idx),
    .rd_ctr (rd_ctr),
    .wr_en  (up_fire),
    .wr_idx (wr_idx),
    .wr_dir (up_taken)
  );

  assign pr_valid = pq_valid;
  assign pr_taken = pq_valid & rd_ctr[CTR_W-1];
  assign pr_hist  = ghist;

endmodule

// File: tb/corr_bpred_test.sv
module corr_bpred_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] SCRATCH = 32'h3C; // row 15

  logic clk = 0;
  logic rst = 1;
  always #(CLK_P/2) clk = ~clk;

  logic pq_valid = 0, up_valid = 0, up_taken = 0;
  logic [31:0] pq_pc = 0, up_pc = 0;
  logic [1:0] up_hist = 0, pr_hist;
  logic pq_ready, up_ready, pr_valid, pr_taken;

  corr_bpred uut (
    .clk(clk), .rst(rst), .pq_valid(pq_valid), .pq_ready(pq_ready), .pq_pc(pq_pc),
    .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_hist(pr_hist),
    .up_valid(up_valid), .up_ready(up_ready), .up_pc(up_pc), .up_taken(up_taken),
    .up_hist(up_hist)
  );

  // (1,1) variant
  logic o_pq_valid = 0, o_up_valid = 0, o_up_taken = 0;
  logic [31:0] o_pq_pc = 0, o_up_pc = 0;
  logic [0:0] o_up_hist = 0, o_pr_hist;
  logic o_pq_ready, o_up_ready, o_pr_valid, o_pr_taken;

  corr_bpred #(.HIST_W(1), .CTR_W(1)) uut_one (
    .clk(clk), .rst(rst), .pq_valid(o_pq_valid), .pq_ready(o_pq_ready), .pq_pc(o_pq_pc),
    .pr_valid(o_pr_valid), .pr_taken(o_pr_taken), .pr_hist(o_pr_hist),
    .up_valid(o_up_valid), .up_ready(o_up_ready), .up_pc(o_up_pc), .up_taken(o_up_taken),
    .up_hist(o_up_hist)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_ctr [64];
  logic [1:0] exp_hist;

  function automatic int idx_of(logic [31:0] pc, logic [1:0] h);
    return int'({pc[5:2], h});
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic upd(logic [31:0] pc, logic t, logic [1:0] h);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = t; up_hist = h;
    @(negedge clk);
    up_valid = 0;
    if (t) exp_ctr[idx_of(pc, h)] = (exp_ctr[idx_of(pc, h)] == 3) ? 3 : exp_ctr[idx_of(pc, h)] + 1;
    else   exp_ctr[idx_of(pc, h)] = (exp_ctr[idx_of(pc, h)] == 0) ? 0 : exp_ctr[idx_of(pc, h)] - 1;
    exp_hist = {exp_hist[0], t};
  endtask

  task automatic set_hist(logic [1:0] h);
    upd(SCRATCH, h[1], exp_hist);
    upd(SCRATCH, h[0], exp_hist);
  endtask

  task automatic see(string req, logic [31:0] pc, int exp_taken);
    @(negedge clk);
    pq_valid = 1; pq_pc = pc;
    #1;
    chk(req, int'(pr_taken), exp_ctr[idx_of(pc, exp_hist)] >= 2 ? 1 : 0);
    chk(req, int'(pr_taken), exp_taken);
    chk(req, int'(pr_hist), int'(exp_hist));
    pq_valid = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R7 hist", int'(pr_hist), 0);
    see("R7", 32'h0, 0);
    see("R7", 32'h28, 0);
    see("R7", 32'hFFFF_FFFC, 0);
  endtask

  task automatic t_handshake;
    upd(32'h10, 1, 2'b00); upd(32'h10, 1, 2'b00);
    @(negedge clk);
    pq_valid = 0; pq_pc = 32'h10;
    #1;
    chk("R9 taken gated", int'(pr_taken), 0);
    chk("R9 pr_valid", int'(pr_valid), 0);
    chk("R9 pq_ready", int'(pq_ready), 1);
    chk("R9 up_ready", int'(up_ready), 1);
    pq_valid = 1;
    #1;
    chk("R9 pr_valid", int'(pr_valid), 1);
    pq_valid = 0;
  endtask

  task automatic t_hist_shift;
    upd(SCRATCH, 1, exp_hist);
    upd(SCRATCH, 0, exp_hist);
    @(negedge clk);
    chk("R1 newest at lsb", int'(pr_hist), 2);
    @(negedge clk); @(negedge clk);
    chk("R1 idle hold", int'(pr_hist), 2);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 4; i++) upd(32'h0C, 1, 2'b00);
    set_hist(2'b00); see("R5 top sat", 32'h0C, 1);
    upd(32'h0C, 0, 2'b00);
    set_hist(2'b00); see("R4 state 10", 32'h0C, 1);
    upd(32'h0C, 0, 2'b00);
    set_hist(2'b00); see("R4 state 01", 32'h0C, 0);
    for (int i = 0; i < 3; i++) upd(32'h0C, 0, 2'b00);
    upd(32'h0C, 1, 2'b00); upd(32'h0C, 1, 2'b00);
    set_hist(2'b00); see("R5 bottom sat", 32'h0C, 1);
  endtask

  task automatic t_saved_hist;
    set_hist(2'b00);
    upd(32'h14, 1, 2'b11); upd(32'h14, 1, 2'b11);
    set_hist(2'b11); see("R6 saved hist trains", 32'h14, 1);
    set_hist(2'b00); see("R6 live column untouched", 32'h14, 0);
    set_hist(2'b01); see("R3 other column", 32'h14, 0);
  endtask

  task automatic t_alias;
    upd(32'h1C, 1, 2'b10); upd(32'h1C, 1, 2'b10);
    set_hist(2'b10);
    see("R2 own row", 32'h1C, 1);
    see("R2 alias high bits", 32'h5C, 1);
    see("R2 alias top bit", 32'h8000_001F, 1);
    see("R2 next row distinct", 32'h20, 0);
  endtask

  task automatic t_collide;
    logic [1:0] h;
    h = exp_hist;
    @(negedge clk);
    pq_valid = 1; pq_pc = 32'h24;
    up_valid = 1; up_pc = 32'h24; up_taken = 1; up_hist = h;
    #1;
    chk("R8 pre-update value", int'(pr_taken), 0);
    @(negedge clk);
    up_valid = 0; pq_valid = 0;
    exp_ctr[idx_of(32'h24, h)] = 2;
    exp_hist = {exp_hist[0], 1'b1};
    set_hist(h); see("R8 written after edge", 32'h24, 1);
  endtask

  task automatic o_upd(logic [31:0] pc, logic t, logic h);
    @(negedge clk);
    o_up_valid = 1; o_up_pc = pc; o_up_taken = t; o_up_hist = h;
    @(negedge clk);
    o_up_valid = 0;
  endtask

  task automatic o_see(string req, logic [31:0] pc, int exp);
    @(negedge clk);
    o_pq_valid = 1; o_pq_pc = pc;
    #1;
    chk(req, int'(o_pr_taken), exp);
    o_pq_valid = 0;
  endtask

  task automatic t_one_one;
    o_see("R10 reset zero", 32'h8, 0);
    o_upd(32'h8, 1, 1'b0);
    o_upd(32'h30, 0, 1'b1);
    @(negedge clk);
    chk("R10 hist", int'(o_pr_hist), 0);
    o_see("R10 set by taken", 32'h8, 1);
    o_upd(32'h8, 0, 1'b0);
    o_see("R10 cleared by one miss", 32'h8, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_ctr[i] = 1;
    exp_hist = 2'b00;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_handshake();
    t_hist_shift();
    t_saturate();
    t_saved_hist();
    t_alias();
    t_collide();
    t_one_one();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule